// File: doc/BRIEF.md
# Configuration Bitstream Streaming Controller

This block moves a partial configuration bitstream from external memory into a 32-bit on-chip configuration port. A single start pulse in the memory clock domain hands it a byte base address and a bitstream length. A burst reader then issues fixed-length read requests. Each request returns BL data beats after a fixed latency. The returned words are written into a dual-clock FIFO. The reader asks for the next burst only when the FIFO can take a whole burst and no earlier burst is still arriving.

In the port clock domain a drain stage pops one word per cycle and raises the port enable in every cycle that it presents a word. It counts the words it has delivered against the programmed length and raises done when the last one has gone. The bursts and the FIFO are sized so that, whenever the memory side supplies more bits per second than the port consumes, the port receives data on every cycle from the first word to the last. A counter of starved port cycles lets the user measure the fraction of port cycles that carried data. The reconfiguration time is then the bitstream size divided by the port clock rate times the port width.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: While either reset is high, and at the first sample after reset, `rd_req`, `cfg_en` and `done` are 0 and `underrun_cnt` is 0.
- R2: A `start` pulse loads `base_addr`. The first burst request carries `rd_addr` equal to that base. Each following request carries the previous address plus BURST_LEN*4 bytes.
- R3: A burst request is raised only when no beats of an earlier burst are still expected and the FIFO has at least BURST_LEN free entries. A transfer of N words issues exactly ceil(N/BURST_LEN) requests, and the FIFO never accepts a write while full.
- R4: The port presents exactly N words, in ascending address order: word k is the memory word at base + 4*k. Beats of the final burst beyond word N are discarded.
- R5: `done` rises one port cycle after the cycle in which the last word is presented. It stays high until the next start is seen, and `cfg_en` is 0 while `done` is high.
- R6: When memory bandwidth exceeds the port bandwidth, `cfg_en` is high on every port cycle from the first word through the last, and `underrun_cnt` stays 0.
- R7: `underrun_cnt` increments on each port cycle after the first delivered word in which words remain but the FIFO is empty. A memory that is too slow gives a non-zero count.
- R8: A new start clears `done` and `underrun_cnt` before the first word of the new transfer, so each transfer is measured on its own.
- R9: A `byte_count` that is not a multiple of 4 is rounded up to whole 32-bit words: N = ceil(byte_count/4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory-side clock |
| mem_rst | input | 1 | Synchronous active-high reset, memory domain |
| start | input | 1 | One-cycle pulse that begins a transfer |
| base_addr | input | ADDR_W | Byte address of the first bitstream word |
| byte_count | input | BYTES_W | Bitstream length in bytes |
| rd_req | output | 1 | Burst read request, accepted on the clock edge |
| rd_addr | output | ADDR_W | Byte address of the requested burst |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | WORD_W | Read data beat |
| port_clk | input | 1 | Configuration port clock |
| port_rst | input | 1 | Synchronous active-high reset, port domain |
| cfg_en | output | 1 | Configuration port write enable |
| cfg_data | output | WORD_W | Word presented to the configuration port |
| done | output | 1 | Transfer finished |
| underrun_cnt | output | UNDER_W | Starved port cycles in the current transfer |

## Verification
A corrupted FIFO pointer or a lost beat shows up at `cfg_data` as a word out of address order. A miscounted length shows up as a word count that differs from N, or as `done` landing on the wrong cycle. Both can be seen within one burst of the fault. A credit or room-check error either stalls the reader, so that `cfg_en` gaps appear and `underrun_cnt` becomes non-zero in a nominal run, or it overwrites unread entries, which corrupts data a few port cycles later. Comparing the burst addresses and the request count against ceil(N/BURST_LEN) exposes wrong address stepping by the second request.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    // log2 of the bytes carried by one data word
    localparam int unsigned WORD_BYTES_LG = 2;

    // burst reader states
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ROOM,
        RD_BEATS
    } rd_state_e;

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/cfg_cdc_fifo.sv
module cfg_cdc_fifo #(
    parameter int unsigned W        = 32,
    parameter int unsigned DEPTH_LG = 5
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic                wr_en,
    input  logic [W-1:0]        wr_data,
    output logic                full,
    output logic [DEPTH_LG:0]   wr_used,
    input  logic                rd_clk,
    input  logic                rd_rst,
    input  logic                rd_en,
    output logic [W-1:0]        rd_data,
    output logic                empty
);
    localparam int unsigned DEPTH = 1 << DEPTH_LG;
    localparam int unsigned PTR_W = DEPTH_LG + 1;

    function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PTR_W-1:0] rd_gray_w, wr_gray_r;

    cfg_sync2 #(.W(PTR_W)) u_rd2wr (.clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_w));
    cfg_sync2 #(.W(PTR_W)) u_wr2rd (.clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_r));

    // write domain
    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            store[wr_bin[DEPTH_LG-1:0]] <= wr_data;
            wr_bin  <= wr_bin + 1'b1;
            wr_gray <= (wr_bin + 1'b1) ^ ((wr_bin + 1'b1) >> 1);
        end
    end

    assign wr_used = wr_bin - gray_to_bin(rd_gray_w);
    assign full    = wr_used[DEPTH_LG];

    // read domain
    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_en) begin
            rd_bin  <= rd_bin + 1'b1;
            rd_gray <= (rd_bin + 1'b1) ^ ((rd_bin + 1'b1) >> 1);
        end
    end

    assign rd_data = store[rd_bin[DEPTH_LG-1:0]];
    assign empty   = (rd_gray == wr_gray_r);

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_en |-> !full); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_en |-> !empty); // R4
endmodule

// File: rtl/cfg_burst_reader.sv
module cfg_burst_reader
    import cfg_stream_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned BYTES_W     = 24,
    parameter int unsigned BURST_LEN   = 16,
    parameter int unsigned FIFO_DEPTH_LG = 5,
    localparam int unsigned WCNT_W     = BYTES_W + 1 - WORD_BYTES_LG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [BYTES_W-1:0]   byte_count,
    input  logic [FIFO_DEPTH_LG:0] fifo_used,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic                 rd_valid,
    output logic                 push,
    output logic [WCNT_W-1:0]    total_words,
    output logic                 start_tgl
);
    localparam int unsigned FIFO_DEPTH = 1 << FIFO_DEPTH_LG;
    localparam int unsigned BEAT_W     = $clog2(BURST_LEN + 1);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BURST_LEN << WORD_BYTES_LG);
    localparam logic [WCNT_W-1:0] BL_WORDS  = WCNT_W'(BURST_LEN);

    rd_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic [WCNT_W-1:0] req_left, wr_left;
    logic [BEAT_W-1:0] beats_left;
    logic [BYTES_W:0]  bytes_up;
    logic [WCNT_W-1:0] words_in;
    logic              room_ok;

    assign bytes_up = {1'b0, byte_count} + (BYTES_W + 1)'(3);
    assign words_in = bytes_up[BYTES_W:WORD_BYTES_LG];
    assign room_ok  = (int'(fifo_used) + int'(BURST_LEN)) <= int'(FIFO_DEPTH);
    assign rd_req   = (state == RD_ROOM) && (req_left != '0) && room_ok;
    assign rd_addr  = addr_q;
    assign push     = rd_valid && (wr_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RD_IDLE;
            addr_q      <= '0;
            req_left    <= '0;
            wr_left     <= '0;
            beats_left  <= '0;
            total_words <= '0;
            start_tgl   <= 1'b0;
        end else if (start) begin
            state       <= RD_ROOM;
            addr_q      <= base_addr;
            req_left    <= words_in;
            wr_left     <= words_in;
            beats_left  <= '0;
            total_words <= words_in;
            start_tgl   <= ~start_tgl;
        end else begin
            if (push) wr_left <= wr_left - 1'b1;
            case (state)
                RD_ROOM: begin
                    if (req_left == '0) begin
                        state <= RD_IDLE;
                    end else if (room_ok) begin
                        addr_q     <= addr_q + ADDR_STEP;
                        req_left   <= (req_left > BL_WORDS) ? req_left - BL_WORDS : '0;
                        beats_left <= BEAT_W'(BURST_LEN);
                        state      <= RD_BEATS;
                    end
                end
                RD_BEATS: begin
                    if (rd_valid) begin
                        beats_left <= beats_left - 1'b1;
                        if (beats_left == BEAT_W'(1)) state <= RD_ROOM;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    AST_BEAT_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (state == RD_BEATS)); // R3
    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R3
endmodule

// File: rtl/cfg_port_drain.sv
module cfg_port_drain #(
    parameter int unsigned WCNT_W  = 23,
    parameter int unsigned UNDER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_tgl_s,
    input  logic [WCNT_W-1:0]  total_in,
    input  logic               fifo_empty,
    output logic               pop,
    output logic               done,
    output logic [UNDER_W-1:0] underrun_cnt
);
    logic              tgl_q, active, started, new_run;
    logic [WCNT_W-1:0] sent, total_q;

    assign new_run = start_tgl_s ^ tgl_q;
    assign pop     = active && !fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_q        <= 1'b0;
            active       <= 1'b0;
            started      <= 1'b0;
            sent         <= '0;
            total_q      <= '0;
            done         <= 1'b0;
            underrun_cnt <= '0;
        end else begin
            tgl_q <= start_tgl_s;
            if (new_run) begin
                total_q      <= total_in;
                sent         <= '0;
                started      <= 1'b0;
                underrun_cnt <= '0;
                done         <= (total_in == '0);
                active       <= (total_in != '0);
            end else if (active) begin
                if (pop) begin
                    sent    <= sent + 1'b1;
                    started <= 1'b1;
                    if (sent == total_q - 1'b1) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end else if (started) begin
                    underrun_cnt <= underrun_cnt + 1'b1;
                end
            end
        end
    end

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !pop); // R5
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !new_run) |=> done); // R5
    AST_SENT_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (sent < total_q)); // R4
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
    import cfg_stream_pkg::*;
#(
    parameter int unsigned WORD_W        = 32,
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned BYTES_W       = 24,
    parameter int unsigned BURST_LEN     = 16,
    parameter int unsigned FIFO_DEPTH_LG = 5,
    parameter int unsigned UNDER_W       = 16
) (
    input  logic                mem_clk,
    input  logic                mem_rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [BYTES_W-1:0]  byte_count,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_valid,
    input  logic [WORD_W-1:0]   rd_data,
    input  logic                port_clk,
    input  logic                port_rst,
    output logic                cfg_en,
    output logic [WORD_W-1:0]   cfg_data,
    output logic                done,
    output logic [UNDER_W-1:0]  underrun_cnt
);
    localparam int unsigned WCNT_W = BYTES_W + 1 - WORD_BYTES_LG;

    logic                   push, fifo_full, fifo_empty, start_tgl, start_tgl_s;
    logic [FIFO_DEPTH_LG:0] fifo_used;
    logic [WCNT_W-1:0]      total_words;

    cfg_burst_reader #(
        .ADDR_W(ADDR_W), .BYTES_W(BYTES_W),
        .BURST_LEN(BURST_LEN), .FIFO_DEPTH_LG(FIFO_DEPTH_LG)
    ) u_reader (
        .clk(mem_clk), .rst(mem_rst), .start(start),
        .base_addr(base_addr), .byte_count(byte_count),
        .fifo_used(fifo_used), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .push(push),
        .total_words(total_words), .start_tgl(start_tgl)
    );

    cfg_cdc_fifo #(.W(WORD_W), .DEPTH_LG(FIFO_DEPTH_LG)) u_fifo (
        .wr_clk(mem_clk), .wr_rst(mem_rst), .wr_en(push), .wr_data(rd_data),
        .full(fifo_full), .wr_used(fifo_used),
        .rd_clk(port_clk), .rd_rst(port_rst), .rd_en(cfg_en),
        .rd_data(cfg_data), .empty(fifo_empty)
    );

    cfg_sync2 #(.W(1)) u_start_sync (
        .clk(port_clk), .rst(port_rst), .d(start_tgl), .q(start_tgl_s)
    );

    cfg_port_drain #(.WCNT_W(WCNT_W), .UNDER_W(UNDER_W)) u_drain (
        .clk(port_clk), .rst(port_rst), .start_tgl_s(start_tgl_s),
        .total_in(total_words), .fifo_empty(fifo_empty), .pop(cfg_en),
        .done(done), .underrun_cnt(underrun_cnt)
    );

    AST_FULL_NO_REQ: assert property (@(posedge mem_clk) disable iff (mem_rst)
        fifo_full |-> !rd_req); // R3
endmodule

// File: tb/test_cfg_stream_ctrl.sv
module test_cfg_stream_ctrl;
    localparam int BL = 16;

    logic        mem_clk = 1'b0, port_clk = 1'b0;
    logic        mem_rst = 1'b1, port_rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [23:0] byte_count = '0;
    logic        rd_req, rd_valid;
    logic [31:0] rd_addr, rd_data;
    logic        cfg_en, done;
    logic [31:0] cfg_data;
    logic [15:0] underrun_cnt;

    always #2  mem_clk  = ~mem_clk;   // memory side, faster than the port
    always #10 port_clk = ~port_clk;  // 50 MHz port clock

    cfg_stream_ctrl i_cfg_stream_ctrl (
        .mem_clk(mem_clk), .mem_rst(mem_rst), .start(start),
        .base_addr(base_addr), .byte_count(byte_count),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .port_clk(port_clk), .port_rst(port_rst), .cfg_en(cfg_en),
        .cfg_data(cfg_data), .done(done), .underrun_cnt(underrun_cnt)
    );

    int total_checks = 0, bad_checks = 0;
    bit finished = 0;

    int          resp_lat = 8;
    logic [31:0] exp_base;
    int exp_words, req_cnt, req_addr_bad;
    int mon_idx, mon_bad, first_cyc, last_cyc, done_cyc, first_done_bad, pcyc = 0;
    logic done_prev = 1'b0;

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] ^ {a[7:0], a[15:8]}};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // burst responder: fixed latency, BL beats per request
    initial begin
        rd_valid = 1'b0;
        rd_data  = '0;
        @(negedge mem_clk);
        forever begin
            if (rd_req) begin
                logic [31:0] a;
                a = rd_addr;
                if (a != exp_base + 32'(req_cnt * BL * 4)) req_addr_bad++;
                req_cnt++;
                repeat (resp_lat) @(negedge mem_clk);
                for (int i = 0; i < BL; i++) begin
                    rd_valid = 1'b1;
                    rd_data  = word_at(a + 32'(4 * i));
                    @(negedge mem_clk);
                end
                rd_valid = 1'b0;
            end else begin
                @(negedge mem_clk);
            end
        end
    end

    // port monitor
    always @(negedge port_clk) begin
        pcyc++;
        if (cfg_en) begin
            if (mon_idx == 0) begin
                first_cyc = pcyc;
                if (done) first_done_bad++;
            end
            if (cfg_data != word_at(exp_base + 32'(4 * mon_idx))) mon_bad++;
            last_cyc = pcyc;
            mon_idx++;
        end
        if (done && !done_prev) done_cyc = pcyc;
        done_prev = done;
    end

    task automatic run_stream(input logic [31:0] b, input int bytes, input int lat,
                              output bit ok);
        exp_base = b; exp_words = (bytes + 3) / 4; resp_lat = lat;
        mon_idx = 0; mon_bad = 0; first_cyc = -1; last_cyc = -1; done_cyc = -1;
        req_cnt = 0; req_addr_bad = 0; first_done_bad = 0;
        @(negedge mem_clk);
        start = 1'b1; base_addr = b; byte_count = 24'(bytes);
        @(negedge mem_clk);
        start = 1'b0;
        for (int i = 0; i < 100 && done; i++) @(negedge port_clk);
        ok = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge port_clk);
            if (done) begin ok = 1; break; end
        end
        repeat (10) @(negedge port_clk);
    endtask

    task automatic t_reset;
        chk("R1 rd_req in reset", int'(rd_req), 0);
        mem_rst = 1'b0; port_rst = 1'b0;
        @(negedge port_clk);
        chk("R1 cfg_en", int'(cfg_en), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 rd_req", int'(rd_req), 0);
        chk("R1 underrun_cnt", int'(underrun_cnt), 0);
    endtask

    task automatic t_nominal(input string tag);
        bit ok;
        int n;
        run_stream(32'h0001_0000, 4096, 8, ok);
        n = mon_idx;
        chk({tag, " R5 done reached"}, int'(ok), 1);
        chk("R4 word count", mon_idx, exp_words);
        chk("R4 data order", mon_bad, 0);
        chk("R2 burst addresses", req_addr_bad, 0);
        chk("R3 request count", req_cnt, (exp_words + BL - 1) / BL);
        chk("R5 done one cycle after last word", done_cyc, last_cyc + 1);
        chk("R6 gapless port cycles", last_cyc - first_cyc + 1, exp_words);
        chk({tag, " R6 underrun zero"}, int'(underrun_cnt), 0);
        repeat (20) @(negedge port_clk);
        chk("R5 no cfg_en after done", mon_idx, n);
        chk("R5 done held", int'(done), 1);
    endtask

    task automatic t_short;
        bit ok;
        run_stream(32'h0000_0400, 32, 8, ok);
        chk("R4 short done", int'(ok), 1);
        chk("R4 short count, excess beats dropped", mon_idx, 8);
        chk("R4 short data", mon_bad, 0);
        chk("R3 short one request", req_cnt, 1);
        chk("R5 short done timing", done_cyc, last_cyc + 1);
    endtask

    task automatic t_round_up;
        bit ok;
        run_stream(32'h0000_2000, 157, 8, ok);
        chk("R9 rounded done", int'(ok), 1);
        chk("R9 157 bytes gives 40 words", mon_idx, 40);
        chk("R9 data", mon_bad, 0);
        chk("R3 partial last burst requests", req_cnt, 3);
        chk("R2 partial addresses", req_addr_bad, 0);
    endtask

    task automatic t_starve;
        bit ok;
        run_stream(32'h0000_8000, 256, 300, ok);
        chk("R7 starved done", int'(ok), 1);
        chk("R7 starved data", mon_bad, 0);
        chk("R7 starved count", mon_idx, 64);
        chk("R7 underrun nonzero", int'(underrun_cnt != 0), 1);
    endtask

    task automatic t_restart;
        t_nominal("R8 restart");
        chk("R8 done low at first word", first_done_bad, 0);
    endtask

    initial begin
        repeat (5) @(negedge port_clk);
        t_reset();
        t_nominal("R6 first");
        t_short();
        t_round_up();
        t_starve();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge port_clk);
        if (!finished) begin
            finished = 1;
            total_checks++;
            bad_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end
endmodule